// File: doc/BRIEF.md
# Dual-Clock Slot Ring Controller

This block arbitrates ownership of a fixed ring of equal-sized buffer slots that live in an external dual-port RAM. A producer in the write clock domain claims an empty slot, fills it with its own word address counter and then hands the slot back as filled. A consumer in the read clock domain claims the oldest filled slot, drains it and then releases it as empty. The two clocks are unrelated. The controller moves only slot ownership across the boundary. It never touches the data.

Each side uses two level-held handshakes. The first is a request answered by an acknowledge pulse and a grant bit. The second is a finish answered by an acknowledge pulse. The slot pointers are Gray coded and pass through two-flop synchronisers. Each side therefore judges "all full" or "all empty" from a copy of the other side's pointer that may be stale, and the error can only be in the safe direction. The block outputs each side's slot index and the RAM base address of that slot: the index placed above the word-offset bits. The user adds the word offset to that base. The write geometry (word width × depth) and the read geometry may differ, provided a slot holds the same number of bits in both. The slot count must be a power of two.

There is no data stream through the block, so all pins are plain control and status levels or pulses. Back-pressure is carried by the grant bit: a refused request means "try again later", and the requester must drop its request and raise it again.

Top module: `slot_ring_ctrl`

## Requirements
- R1: After each domain's synchronous active-high reset, both slot indices and both base addresses are 0, no acknowledge is high, and every slot is empty, so the first read request is refused with a grant bit of 0.
- R2: A write request sampled high on a write clock edge, while no slot is held, produces `wr_req_ack` high for exactly one cycle after that edge. `wr_req_ok` is 1 in that cycle when a free slot exists, and `wr_req_ok` is never high without the acknowledge.
- R3: A write request made while all SLOT_NUM slots are filled and not yet released is acknowledged with `wr_req_ok` = 0, and the write slot index does not change.
- R4: A write finish sampled high while a slot is held produces a single-cycle `wr_fin_ack` one cycle later. In that same cycle the write slot index has advanced by one, modulo SLOT_NUM.
- R5: A read request is granted (`rd_req_ok` = 1) only when at least one filled slot is waiting. When the ring is empty it is acknowledged with `rd_req_ok` = 0.
- R6: A read finish on a held slot produces a single-cycle `rd_fin_ack` one cycle later, with the read index advanced by one modulo SLOT_NUM. The slot then becomes free for the writer again.
- R7: Slots are read in exactly the order in which they were written: the n-th granted read slot index equals the n-th finished write slot index, both being n modulo SLOT_NUM.
- R8: A request raised while that side already holds a slot gets no acknowledge. A finish raised while that side holds no slot gets no acknowledge. In both cases the slot index is unchanged.
- R9: After any request acknowledge, a request input that stays high receives no further acknowledge until it has been seen low on at least one clock edge.
- R10: The write base address equals the write slot index times WR_DEPTH. The read base address equals the read slot index times RD_DEPTH. Both depths are powers of two.
- R11: After a write finish acknowledge, a read request sampled on the third read clock edge that follows is granted. After a read finish acknowledge, a write request sampled on the third write clock edge that follows can use the freed slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Producer clock |
| wr_rst | input | 1 | Synchronous active-high reset, producer domain |
| wr_req | input | 1 | Producer asks for an empty slot (level, held until acknowledge) |
| wr_fin | input | 1 | Producer reports the held slot filled (level, held until acknowledge) |
| wr_req_ack | output | 1 | One-cycle answer to `wr_req` |
| wr_req_ok | output | 1 | Grant bit, valid with `wr_req_ack`: 1 = slot granted, 0 = all full |
| wr_fin_ack | output | 1 | One-cycle answer to `wr_fin` |
| wr_slot_idx | output | $clog2(SLOT_NUM) | Slot the producer owns or will own next |
| wr_base_addr | output | $clog2(SLOT_NUM)+$clog2(WR_DEPTH) | RAM word address of word 0 of that slot, write port |
| rd_clk | input | 1 | Consumer clock |
| rd_rst | input | 1 | Synchronous active-high reset, consumer domain |
| rd_req | input | 1 | Consumer asks for a filled slot |
| rd_fin | input | 1 | Consumer reports the held slot drained |
| rd_req_ack | output | 1 | One-cycle answer to `rd_req` |
| rd_req_ok | output | 1 | Grant bit, valid with `rd_req_ack`: 1 = slot granted, 0 = none filled |
| rd_fin_ack | output | 1 | One-cycle answer to `rd_fin` |
| rd_slot_idx | output | $clog2(SLOT_NUM) | Slot the consumer owns or will own next |
| rd_base_addr | output | $clog2(SLOT_NUM)+$clog2(RD_DEPTH) | RAM word address of word 0 of that slot, read port |

## Verification
Within one side, every answer is registered. An input that is high on one edge of that side's clock shows its acknowledge, grant bit and updated index right after that edge, and the acknowledge has fallen again after the next edge. The bench drives inputs on falling edges and reads outputs on the following falling edge, so each check sits exactly one cycle after its stimulus. It also checks the edge after that to confirm the pulse has ended.

Across the two sides, a finish becomes visible after the synchroniser delay. The ring-order sweeps therefore wait four cycles of the receiving clock before each cross-side request, so their expected results depend only on slot counts. One check places the read request exactly on the third read edge after the write finish acknowledge, to test the R11 bound. The sweep runs fill levels 1 to SLOT_NUM twice over, and the index checks wrap through the ring several times.

// File: rtl/slot_ring_pkg.sv
package slot_ring_pkg;

  // ownership state of one side of the ring
  typedef enum logic {
    ST_FREE = 1'b0,   // no slot claimed by this side
    ST_HELD = 1'b1    // a slot is claimed and not yet finished
  } hold_st_t;

  // which end of the ring a side controller serves
  typedef enum logic {
    SIDE_WRITE = 1'b0,
    SIDE_READ  = 1'b1
  } side_e;

endpackage

// File: rtl/ring_gray_sync.sv
module ring_gray_sync #(
  parameter int W = 3
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] gray_in,
  output logic [W-1:0] bin_out
);

  logic [W-1:0] stage1;
  logic [W-1:0] stage2;

  // two flops in the receiving domain; only one bit of gray_in moves per step
  always_ff @(posedge clk) begin
    if (rst) begin
      stage1 <= '0;
      stage2 <= '0;
    end else begin
      stage1 <= gray_in;
      stage2 <= stage1;
    end
  end

  // Gray to binary: each bit is the XOR of all Gray bits at or above it
  assign bin_out[W-1] = stage2[W-1];
  for (genvar i = W - 2; i >= 0; i--) begin : g_g2b
    assign bin_out[i] = bin_out[i+1] ^ stage2[i];
  end

endmodule

// File: rtl/ring_side.sv
module ring_side
  import slot_ring_pkg::*;
#(
  parameter int    PW   = 3,
  parameter side_e SIDE = SIDE_WRITE
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req,
  input  logic          fin,
  input  logic [PW-1:0] far_bin,
  output logic          req_ack,
  output logic          req_ok,
  output logic          fin_ack,
  output logic [PW-1:0] ptr_bin,
  output logic [PW-1:0] ptr_gray
);

  // slot count is the weight of the wrap bit
  localparam logic [PW-1:0] RING = PW'(1) << (PW - 1);

  hold_st_t      st;
  logic          armed;
  logic          avail;
  logic [PW-1:0] fill;
  logic [PW-1:0] ptr_nxt;

  assign ptr_nxt = ptr_bin + PW'(1);
  assign fill    = ptr_bin - far_bin;

  // the far pointer may lag; the writer then sees more full, the reader more empty
  if (SIDE == SIDE_WRITE) begin : g_wr_avail
    assign avail = (fill != RING);
  end else begin : g_rd_avail
    assign avail = (fill != '0);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= ST_FREE;
      armed    <= 1'b1;
      req_ack  <= 1'b0;
      req_ok   <= 1'b0;
      fin_ack  <= 1'b0;
      ptr_bin  <= '0;
      ptr_gray <= '0;
    end else begin
      req_ack <= 1'b0;
      req_ok  <= 1'b0;
      fin_ack <= 1'b0;
      if (!req) begin
        armed <= 1'b1;
      end
      unique case (st)
        ST_FREE: begin
          if (req && armed) begin
            req_ack <= 1'b1;
            req_ok  <= avail;
            armed   <= 1'b0;
            if (avail) begin
              st <= ST_HELD;
            end
          end
        end
        ST_HELD: begin
          if (fin) begin
            fin_ack  <= 1'b1;
            ptr_bin  <= ptr_nxt;
            ptr_gray <= ptr_nxt ^ (ptr_nxt >> 1);
            st       <= ST_FREE;
          end
        end
        default: st <= ST_FREE;
      endcase
    end
  end

endmodule

// File: rtl/slot_ring_ctrl.sv
module slot_ring_ctrl
  import slot_ring_pkg::*;
#(
  parameter int WR_W     = 8,
  parameter int WR_DEPTH = 16,
  parameter int RD_W     = 16,
  parameter int RD_DEPTH = 8,
  parameter int SLOT_NUM = 4,
  localparam int IDX_W   = $clog2(SLOT_NUM),
  localparam int WOFF_W  = $clog2(WR_DEPTH),
  localparam int ROFF_W  = $clog2(RD_DEPTH)
) (
  input  logic                    wr_clk,
  input  logic                    wr_rst,
  input  logic                    wr_req,
  input  logic                    wr_fin,
  output logic                    wr_req_ack,
  output logic                    wr_req_ok,
  output logic                    wr_fin_ack,
  output logic [IDX_W-1:0]        wr_slot_idx,
  output logic [IDX_W+WOFF_W-1:0] wr_base_addr,
  input  logic                    rd_clk,
  input  logic                    rd_rst,
  input  logic                    rd_req,
  input  logic                    rd_fin,
  output logic                    rd_req_ack,
  output logic                    rd_req_ok,
  output logic                    rd_fin_ack,
  output logic [IDX_W-1:0]        rd_slot_idx,
  output logic [IDX_W+ROFF_W-1:0] rd_base_addr
);

  // pointer carries one wrap bit above the slot index
  localparam int PW = IDX_W + 1;

  if (WR_W * WR_DEPTH != RD_W * RD_DEPTH) begin : g_bad_geom
    $error("write and read slot sizes differ");
  end

  logic [PW-1:0] wptr_bin, wptr_gray, wptr_in_rd;
  logic [PW-1:0] rptr_bin, rptr_gray, rptr_in_wr;

  ring_side #(
    .PW   (PW),
    .SIDE (SIDE_WRITE)
  ) u_wr_side (
    .clk      (wr_clk),
    .rst      (wr_rst),
    .req      (wr_req),
    .fin      (wr_fin),
    .far_bin  (rptr_in_wr),
    .req_ack  (wr_req_ack),
    .req_ok   (wr_req_ok),
    .fin_ack  (wr_fin_ack),
    .ptr_bin  (wptr_bin),
    .ptr_gray (wptr_gray)
  );

  ring_side #(
    .PW   (PW),
    .SIDE (SIDE_READ)
  ) u_rd_side (
    .clk      (rd_clk),
    .rst      (rd_rst),
    .req      (rd_req),
    .fin      (rd_fin),
    .far_bin  (wptr_in_rd),
    .req_ack  (rd_req_ack),
    .req_ok   (rd_req_ok),
    .fin_ack  (rd_fin_ack),
    .ptr_bin  (rptr_bin),
    .ptr_gray (rptr_gray)
  );

  ring_gray_sync #(.W(PW)) u_w2r (
    .clk     (rd_clk),
    .rst     (rd_rst),
    .gray_in (wptr_gray),
    .bin_out (wptr_in_rd)
  );

  ring_gray_sync #(.W(PW)) u_r2w (
    .clk     (wr_clk),
    .rst     (wr_rst),
    .gray_in (rptr_gray),
    .bin_out (rptr_in_wr)
  );

  assign wr_slot_idx  = wptr_bin[IDX_W-1:0];
  assign rd_slot_idx  = rptr_bin[IDX_W-1:0];
  assign wr_base_addr = {wr_slot_idx, {WOFF_W{1'b0}}};
  assign rd_base_addr = {rd_slot_idx, {ROFF_W{1'b0}}};

endmodule

// File: rtl/slot_ring_ctrl_chk.sv
module slot_ring_ctrl_chk #(
  parameter int IDX_W = 2
) (
  input logic             wr_clk,
  input logic             wr_rst,
  input logic             wr_req_ack,
  input logic             wr_req_ok,
  input logic             wr_fin_ack,
  input logic [IDX_W-1:0] wr_slot_idx,
  input logic             rd_clk,
  input logic             rd_rst,
  input logic             rd_req_ack,
  input logic             rd_req_ok,
  input logic             rd_fin_ack,
  input logic [IDX_W-1:0] rd_slot_idx
);

  a_r2_wr_ack_pulse: assert property (@(posedge wr_clk) disable iff (wr_rst)
    wr_req_ack |=> !wr_req_ack);

  a_r2_wr_ok_needs_ack: assert property (@(posedge wr_clk) disable iff (wr_rst)
    wr_req_ok |-> wr_req_ack);

  a_r4_wr_idx_step: assert property (@(posedge wr_clk) disable iff (wr_rst)
    wr_fin_ack |-> (wr_slot_idx == IDX_W'($past(wr_slot_idx) + 1'b1)));

  a_r8_wr_idx_hold: assert property (@(posedge wr_clk) disable iff (wr_rst)
    !wr_fin_ack |-> $stable(wr_slot_idx));

  a_r8_wr_ack_excl: assert property (@(posedge wr_clk) disable iff (wr_rst)
    $onehot0({wr_req_ack, wr_fin_ack}));

  a_r5_rd_ack_pulse: assert property (@(posedge rd_clk) disable iff (rd_rst)
    rd_req_ack |=> !rd_req_ack);

  a_r5_rd_ok_needs_ack: assert property (@(posedge rd_clk) disable iff (rd_rst)
    rd_req_ok |-> rd_req_ack);

  a_r6_rd_idx_step: assert property (@(posedge rd_clk) disable iff (rd_rst)
    rd_fin_ack |-> (rd_slot_idx == IDX_W'($past(rd_slot_idx) + 1'b1)));

  a_r8_rd_idx_hold: assert property (@(posedge rd_clk) disable iff (rd_rst)
    !rd_fin_ack |-> $stable(rd_slot_idx));

  a_r8_rd_ack_excl: assert property (@(posedge rd_clk) disable iff (rd_rst)
    $onehot0({rd_req_ack, rd_fin_ack}));

endmodule

bind slot_ring_ctrl slot_ring_ctrl_chk #(.IDX_W(IDX_W)) u_chk (
  .wr_clk      (wr_clk),
  .wr_rst      (wr_rst),
  .wr_req_ack  (wr_req_ack),
  .wr_req_ok   (wr_req_ok),
  .wr_fin_ack  (wr_fin_ack),
  .wr_slot_idx (wr_slot_idx),
  .rd_clk      (rd_clk),
  .rd_rst      (rd_rst),
  .rd_req_ack  (rd_req_ack),
  .rd_req_ok   (rd_req_ok),
  .rd_fin_ack  (rd_fin_ack),
  .rd_slot_idx (rd_slot_idx)
);

// File: tb/slot_ring_ctrl_bench.sv
module slot_ring_ctrl_bench;

  localparam int WCLK_PERIOD = 10;
  localparam int RCLK_PERIOD = 14;
  localparam int SLOTS       = 4;
  localparam int WDEP        = 16;
  localparam int RDEP        = 8;

  logic wr_clk = 1'b0;
  logic rd_clk = 1'b0;
  logic wr_rst = 1'b1;
  logic rd_rst = 1'b1;
  logic wr_req = 1'b0;
  logic wr_fin = 1'b0;
  logic rd_req = 1'b0;
  logic rd_fin = 1'b0;
  logic wr_req_ack, wr_req_ok, wr_fin_ack;
  logic rd_req_ack, rd_req_ok, rd_fin_ack;
  logic [1:0] wr_slot_idx, rd_slot_idx;
  logic [5:0] wr_base_addr;
  logic [4:0] rd_base_addr;

  int checks = 0;
  int errors = 0;
  int wcnt   = 0;
  int rcnt   = 0;
  int cycles = 0;
  logic done = 1'b0;

  always #(WCLK_PERIOD / 2) wr_clk = ~wr_clk;
  always #(RCLK_PERIOD / 2) rd_clk = ~rd_clk;

  slot_ring_ctrl #(
    .WR_W(8), .WR_DEPTH(WDEP), .RD_W(16), .RD_DEPTH(RDEP), .SLOT_NUM(SLOTS)
  ) u_slot_ring_ctrl (
    .wr_clk(wr_clk), .wr_rst(wr_rst), .wr_req(wr_req), .wr_fin(wr_fin),
    .wr_req_ack(wr_req_ack), .wr_req_ok(wr_req_ok), .wr_fin_ack(wr_fin_ack),
    .wr_slot_idx(wr_slot_idx), .wr_base_addr(wr_base_addr),
    .rd_clk(rd_clk), .rd_rst(rd_rst), .rd_req(rd_req), .rd_fin(rd_fin),
    .rd_req_ack(rd_req_ack), .rd_req_ok(rd_req_ok), .rd_fin_ack(rd_fin_ack),
    .rd_slot_idx(rd_slot_idx), .rd_base_addr(rd_base_addr)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic wr_ask(output logic ack, output logic ok);
    @(negedge wr_clk) wr_req = 1'b1;
    @(negedge wr_clk);
    ack = wr_req_ack; ok = wr_req_ok; wr_req = 1'b0;
    @(negedge wr_clk);
    chk("R2 write ack pulse ends", int'(wr_req_ack), 0);
  endtask

  task automatic wr_done(output logic ack);
    @(negedge wr_clk) wr_fin = 1'b1;
    @(negedge wr_clk);
    ack = wr_fin_ack; wr_fin = 1'b0;
  endtask

  task automatic rd_ask(output logic ack, output logic ok);
    @(negedge rd_clk) rd_req = 1'b1;
    @(negedge rd_clk);
    ack = rd_req_ack; ok = rd_req_ok; rd_req = 1'b0;
    @(negedge rd_clk);
    chk("R5 read ack pulse ends", int'(rd_req_ack), 0);
  endtask

  task automatic rd_done(output logic ack);
    @(negedge rd_clk) rd_fin = 1'b1;
    @(negedge rd_clk);
    ack = rd_fin_ack; rd_fin = 1'b0;
  endtask

  // watchdog
  always @(posedge wr_clk) begin
    cycles++;
    if (cycles > 100000 && !done) begin
      errors++;
      $display("FAIL watchdog actual %0d expected %0d", cycles, 100000);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic ack, ok;
    int n;
    repeat (3) @(negedge wr_clk);
    wr_rst = 1'b0;
    repeat (3) @(negedge rd_clk);
    rd_rst = 1'b0;
    @(negedge wr_clk);
    // R1 reset state
    chk("R1 write index", int'(wr_slot_idx), 0);
    chk("R1 write base", int'(wr_base_addr), 0);
    chk("R1 write acks", int'(wr_req_ack | wr_fin_ack), 0);
    chk("R1 read index", int'(rd_slot_idx), 0);
    chk("R1 read base", int'(rd_base_addr), 0);
    chk("R1 read acks", int'(rd_req_ack | rd_fin_ack), 0);
    rd_ask(ack, ok);
    chk("R1 empty read ack", int'(ack), 1);
    chk("R1 empty read refused", int'(ok), 0);

    // R8 finish with no slot held is ignored
    @(negedge wr_clk) wr_fin = 1'b1;
    n = 0;
    repeat (4) begin @(negedge wr_clk); if (wr_fin_ack) n++; end
    wr_fin = 1'b0;
    chk("R8 idle finish no ack", n, 0);
    chk("R8 idle finish index", int'(wr_slot_idx), 0);

    for (int round = 0; round < 2; round++) begin
      for (int k = 1; k <= SLOTS; k++) begin
        for (int i = 0; i < k; i++) begin
          wr_ask(ack, ok);
          chk("R2 write ack", int'(ack), 1);
          chk("R2 write granted", int'(ok), 1);
          chk("R10 write index", int'(wr_slot_idx), wcnt % SLOTS);
          chk("R10 write base", int'(wr_base_addr), (wcnt % SLOTS) * WDEP);
          wr_done(ack);
          chk("R4 write finish ack", int'(ack), 1);
          chk("R4 write index step", int'(wr_slot_idx), (wcnt + 1) % SLOTS);
          @(negedge wr_clk);
          chk("R4 finish ack pulse ends", int'(wr_fin_ack), 0);
          wcnt++;
        end
        if (k == SLOTS) begin
          // R3 full refusal, R9 held request answered once
          @(negedge wr_clk) wr_req = 1'b1;
          n = 0; ok = 1'b0;
          repeat (6) begin
            @(negedge wr_clk);
            if (wr_req_ack) begin n++; ok = wr_req_ok; end
          end
          wr_req = 1'b0;
          chk("R9 single ack for held request", n, 1);
          chk("R3 full write refused", int'(ok), 0);
          chk("R3 full index unchanged", int'(wr_slot_idx), wcnt % SLOTS);
        end
        repeat (4) @(negedge rd_clk);
        for (int i = 0; i < k; i++) begin
          rd_ask(ack, ok);
          chk("R5 read ack", int'(ack), 1);
          chk("R5 read granted", int'(ok), 1);
          chk("R7 read order index", int'(rd_slot_idx), rcnt % SLOTS);
          chk("R10 read base", int'(rd_base_addr), (rcnt % SLOTS) * RDEP);
          // R8 request while holding is ignored
          @(negedge rd_clk) rd_req = 1'b1;
          n = 0;
          repeat (4) begin @(negedge rd_clk); if (rd_req_ack) n++; end
          rd_req = 1'b0;
          chk("R8 held-slot request no ack", n, 0);
          chk("R8 held-slot index", int'(rd_slot_idx), rcnt % SLOTS);
          rd_done(ack);
          chk("R6 read finish ack", int'(ack), 1);
          chk("R6 read index step", int'(rd_slot_idx), (rcnt + 1) % SLOTS);
          rcnt++;
        end
        rd_ask(ack, ok);
        chk("R5 drained read refused", int'(ok), 0);
        repeat (4) @(negedge wr_clk);
      end
    end

    // R6 after draining a full ring, the writer can fill every slot again
    // (covered by the k loop restarting); R11 bound check on fresh ring
    wr_ask(ack, ok);
    chk("R11 write granted", int'(ok), 1);
    @(negedge wr_clk) wr_fin = 1'b1;
    @(negedge wr_clk);
    chk("R11 write finish ack", int'(wr_fin_ack), 1);
    wr_fin = 1'b0;
    @(posedge rd_clk);
    @(posedge rd_clk);
    @(negedge rd_clk) rd_req = 1'b1;
    @(negedge rd_clk);
    chk("R11 read ack on third edge", int'(rd_req_ack), 1);
    chk("R11 read granted on third edge", int'(rd_req_ok), 1);
    rd_req = 1'b0;
    chk("R7 read index after bound test", int'(rd_slot_idx), rcnt % SLOTS);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule